// File: doc/BRIEF.md
# Watchdog Timer with Exportable Reset Pulse

This block guards a processor against a hung program. Software writes a reload value into a data register and sets the run bit of a control register. After that, a down-counter steps once every `DIV` clocks of the undoubled oscillator. Software must refresh it with the kick bit before it runs out.

If the counter runs out, the block sets a sticky timeout flag. If resetting is enabled, it also raises a one-cycle internal reset request. If the export bit is also set, it drives the external reset pin for a fixed pulse of `PULSE_LEN` clocks.

The block has no clock-rate input. It steps on the oscillator clock it is given, so a doubled CPU clock elsewhere on the chip cannot change its period. Register access is a plain write strobe per register plus a read-back of the control byte.

Top module: `wdog_rstexp`

## Requirements
- R1: After reset, the control read-back is 0x00 and both `wd_rst_int` and `rst_pin_drv` are low.
- R2: The control byte has this layout:
  - bit 0 is run.
  - bit 1 is kick. It is write-only and always reads 0.
  - bit 2 is the timeout flag.
  - bit 3 is reset enable.
  - bit 4 is pin export enable.
  - bits 7:5 always read 0.
- R3: Setting run (0 to 1) loads the counter from the reload register. The timeout flag then sets exactly (reload+1)*DIV clocks after the write edge. The counter then reloads by itself and times out again after the same period.
- R4: Writing the control byte with the kick bit set reloads the counter and restarts the prescaler. Kicks spaced closer than the period prevent any timeout. After the last kick, a timeout follows (reload+1)*DIV clocks later.
- R5: The timeout flag sets on timeout and stays set. A control write with bit 2 = 0 clears it. A control write with bit 2 = 1 never sets it.
- R6: With reset enable set, `wd_rst_int` is high for exactly one clock, on the same edge at which the flag sets. With reset enable clear, it stays low.
- R7: With both reset enable and export enable set, `rst_pin_drv` rises on the timeout edge and stays high for PULSE_LEN (32) clocks.
- R8: If either reset enable or export enable is clear, `rst_pin_drv` is never driven.
- R9: While run is 0, the counter holds and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undoubled system oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control write data |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_wdata | input | RLD_W | Reload value |
| ctl_rdata | output | 8 | Control byte read-back |
| wd_rst_int | output | 1 | One-clock internal reset request |
| rst_pin_drv | output | 1 | Drive enable for the external reset pin |

## Verification
The bench measures the timeout cycle for several reload values and enable combinations. An off-by-one in the expiry compare or in the prescaler would shift the flag by one tick or one clock.

It also checks the following:
- Kicks that keep the watchdog alive. A broken refresh lets the flag set.
- The exported pulse length. A wrong stretch count gives a pulse other than 32 clocks.
- The gating of the pin by both enables. A gate missing either enable drives the pin when it should not.
- Flag clearing by a write of 0 but not by a write of 1. A wrong write rule leaves the flag stuck or clears it.
- Halting while run is clear. A counter that ignores run times out anyway.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CTL_RUN   = 0;
    localparam int CTL_KICK  = 1;
    localparam int CTL_FLAG  = 2;
    localparam int CTL_RSTEN = 3;
    localparam int CTL_OUTEN = 4;
    localparam int CTL_W     = 8;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } presc_t;

    presc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i || clr_i) begin
            st_d.pre = '0;
        end else if (st_q.pre == LAST) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
        tick_o = run_i && !clr_i && (st_q.pre == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: ticks are spaced at least two clocks apart
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         load_i,
    input  logic         tick_i,
    input  logic [W-1:0] rld_i,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = rld_i;
        end else if (run_i && tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = rld_i;
                expire_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a tick on a nonzero count steps it down by one
    p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - W'(1));
    // R9: halted counter holds its value
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(st_q.cnt));
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
    parameter int LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_t;

    str_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_i) begin
            st_d.cnt = CW'(LEN);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        pulse_o = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: without a new trigger the pulse counter only runs down
    p_pulse_runs_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !trig_i) |=> st_q.cnt == $past(st_q.cnt) - CW'(1));
endmodule

// File: rtl/wdog_rstexp.sv
module wdog_rstexp #(
    parameter int RLD_W     = 8,
    parameter int DIV       = 4,
    parameter int PULSE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             rld_we,
    input  logic [RLD_W-1:0] rld_wdata,
    output logic [7:0]       ctl_rdata,
    output logic             wd_rst_int,
    output logic             rst_pin_drv
);
    import wdog_pkg::*;

    typedef struct packed {
        logic             run;
        logic             rst_en;
        logic             out_en;
        logic             flag;
        logic             rst_int;
        logic [RLD_W-1:0] rld;
    } top_t;

    top_t st_d, st_q;
    logic start, kick, load, tick, expire, pin_trig;

    assign start = ctl_we && ctl_wdata[CTL_RUN] && !st_q.run;
    assign kick  = ctl_we && ctl_wdata[CTL_KICK];
    assign load  = start || kick;

    wdog_presc #(.DIV(DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.run),
        .clr_i  (load),
        .tick_o (tick)
    );

    wdog_count #(.W(RLD_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run),
        .load_i   (load),
        .tick_i   (tick),
        .rld_i    (st_q.rld),
        .expire_o (expire)
    );

    assign pin_trig = expire && st_q.rst_en && st_q.out_en;

    wdog_stretch #(.LEN(PULSE_LEN)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (pin_trig),
        .pulse_o (rst_pin_drv)
    );

    always_comb begin
        st_d = st_q;
        if (rld_we) begin
            st_d.rld = rld_wdata;
        end
        if (ctl_we) begin
            st_d.run    = ctl_wdata[CTL_RUN];
            st_d.rst_en = ctl_wdata[CTL_RSTEN];
            st_d.out_en = ctl_wdata[CTL_OUTEN];
            st_d.flag   = st_q.flag && ctl_wdata[CTL_FLAG];
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end
        st_d.rst_int = expire && st_q.rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_rdata            = '0;
        ctl_rdata[CTL_RUN]   = st_q.run;
        ctl_rdata[CTL_FLAG]  = st_q.flag;
        ctl_rdata[CTL_RSTEN] = st_q.rst_en;
        ctl_rdata[CTL_OUTEN] = st_q.out_en;
    end

    assign wd_rst_int = st_q.rst_int;

    // R6: an internal reset request comes with the timeout flag
    p_int_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_int |-> ctl_rdata[CTL_FLAG]);
    // R6: the internal request lasts one clock
    p_int_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_int |=> !wd_rst_int);
    // R8: the pin only starts together with an internal request
    p_pin_with_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pin_drv) |-> wd_rst_int);
    // R5: the flag cannot rise without a timeout
    p_flag_from_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(expire));
endmodule

// File: tb/sim_wdog_rstexp.sv
`timescale 1ns/1ps
module sim_wdog_rstexp;
    localparam int DIV  = 4;
    localparam int PLEN = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       rld_we = 1'b0;
    logic [7:0] rld_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       wd_rst_int;
    logic       rst_pin_drv;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdog_rstexp u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata), .ctl_rdata(ctl_rdata),
        .wd_rst_int(wd_rst_int), .rst_pin_drv(rst_pin_drv)
    );

    // each entry: reload[9:2], reset enable[1], export enable[0]
    localparam logic [9:0] VEC [6] = '{
        {8'd0,  1'b1, 1'b1},
        {8'd3,  1'b1, 1'b0},
        {8'd5,  1'b0, 1'b1},
        {8'd10, 1'b1, 1'b1},
        {8'd7,  1'b0, 1'b0},
        {8'd20, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_rld(input logic [7:0] v);
        @(negedge clk); rld_we = 1'b1; rld_wdata = v;
        @(negedge clk); rld_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // counts clocks after the current write edge until the flag sets
    task automatic wait_flag(input int limit, output int n);
        n = 0;
        while (!ctl_rdata[2] && n < limit) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 int", wd_rst_int, 0);
        chk("R1 pin", rst_pin_drv, 0);

        // R3 R6 R7 R8 vector walk
        foreach (VEC[i]) begin
            int rl, re, oe, per, pin_ones, int_at;
            rl = VEC[i][9:2]; re = VEC[i][1]; oe = VEC[i][0];
            per = (rl + 1) * DIV;
            do_reset();
            wr_rld(8'(rl));
            wr_ctl({3'b000, 1'(oe), 1'(re), 3'b001});
            wait_flag(500, n);
            chk("R3 timeout cycle", n, per);
            chk("R6 int at timeout", wd_rst_int, re);
            chk("R8 pin at timeout", rst_pin_drv, re & oe);
            pin_ones = 0; int_at = 0;
            for (int p = 1; p <= per; p++) begin
                @(negedge clk);
                if (p < per && rst_pin_drv) pin_ones++;
                if (wd_rst_int && int_at == 0) int_at = p;
            end
            chk("R7 pin length", pin_ones, (re & oe) ? ((per - 1 < PLEN - 1) ? per - 1 : PLEN - 1) : 0);
            chk("R3 reload period", int_at, re ? per : 0);
        end

        // R2 layout: write all ones
        do_reset();
        wr_rld(8'd50);
        wr_ctl(8'hFF);
        chk("R2 read after 0xFF", ctl_rdata, 8'h19);

        // R4 kicks keep it alive
        do_reset();
        wr_rld(8'd3);
        wr_ctl(8'h09);
        for (int k = 0; k < 8; k++) begin
            repeat (10) @(negedge clk);
            wr_ctl(8'h0B);
        end
        chk("R4 no timeout while kicked", ctl_rdata[2], 0);
        chk("R2 kick reads 0", ctl_rdata[1], 0);
        wait_flag(500, n);
        chk("R4 timeout after last kick", n, 16);

        // R5 flag write rules (stop first)
        wr_ctl(8'h04);
        chk("R5 write 1 keeps flag", ctl_rdata[2], 1);
        wr_ctl(8'h00);
        chk("R5 write 0 clears flag", ctl_rdata[2], 0);
        wr_ctl(8'h04);
        chk("R5 write 1 does not set", ctl_rdata[2], 0);

        // R9 halted: no timeout
        wr_ctl(8'h18);
        begin
            int seen;
            seen = 0;
            repeat (100) begin
                @(negedge clk);
                if (ctl_rdata[2] || wd_rst_int || rst_pin_drv) seen = 1;
            end
            chk("R9 halted no timeout", seen, 0);
        end
        // R9 resume restarts from the full reload
        wr_ctl(8'h19);
        wait_flag(500, n);
        chk("R9 restart period", n, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule